// File: doc/BRIEF.md
# Lockable GPIO Port Register Block

This block is the register side of a 16-pin general-purpose I/O port. Software reaches it through a simple word-addressed register bus. For each pin it holds a direction mode, an output type, a speed setting, a pull request and a 4-bit alternate-function selector. It also holds an output data register, a synchronised input data register and a write-only register that sets and clears output bits atomically. Its outputs are plain per-pin signals for the pad ring: output value, output enable, open-drain flag, pull-up and pull-down requests, and the alternate-function index.

A keyed lock engine guards the configuration. Software writes the lock register three times with the same pin mask, and the key bit must go 1, then 0, then 1. After the third write, the mode, output type, speed, pull and alternate-function fields of the masked pins ignore every write until the next reset. Output data is never locked.

Register word addresses: 0 mode, 1 output type, 2 speed, 3 pull, 4 input data, 5 output data, 6 set/clear, 7 lock, 8 alternate function for pins 0 to 7, 9 alternate function for pins 8 to 15. Read data is combinational from the address. Writes take effect at the clock edge where the write strobe is sampled.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset, every configuration register, the output data register and the lock register read 0. All pins are inputs with no output enable, no open-drain flag, no pull and alternate function 0.
- R2: The mode field of pin n is bits 2n+1:2n of address 0, coded 00 input, 01 output, 10 alternate function and 11 analog. Output enable is high for codes 01 and 10. The pin output value is the output data bit for code 01 and the pin's alt_dout bit for code 10.
- R3: Output type bit n of address 1 set to 1 selects open-drain, and the open-drain flag is high only while the pin's output is enabled. The pull field, bits 2n+1:2n of address 3, is coded 01 pull-up, 10 pull-down, and 00 or 11 for no pull. The speed field, bits 2n+1:2n of address 2, is stored and reads back.
- R4: The alternate-function selector of pin n sits at bits 4(n mod 8)+3:4(n mod 8) of address 8 for pins 0 to 7 and of address 9 for pins 8 to 15. The selector appears on pin_af[4n+3:4n].
- R5: A write to address 6 sets output bit n when data bit n is 1 and clears it when data bit n+16 is 1. When both bits are 1, the set wins. Bits written as 0 leave the output unchanged, and address 6 reads as 0.
- R6: Three consecutive writes to address 7 with the same mask in bits 15:0 and bit 16 equal to 1, then 0, then 1 lock the masked pins. Address 7 then reads bit 16 as 1 and bits 15:0 as the mask. Both stay fixed until reset, and later lock writes have no effect.
- R7: For locked pins, writes to addresses 0, 1, 2, 3, 8 and 9 leave the fields unchanged, while the fields of unlocked pins in the same write are updated.
- R8: A lock write whose mask differs from the first step's mask, or whose key bit is out of order, aborts the sequence to idle with nothing locked.
- R9: The output data register at address 5 and the set/clear register keep working after a lock.
- R10: The pad input is sampled through two flops, so a change becomes readable at address 4 after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 16 | Pad input levels |
| alt_dout | input | 16 | Output values from alternate-function peripherals |
| pin_out | output | 16 | Per-pin output value |
| pin_oe | output | 16 | Per-pin output enable |
| pin_od | output | 16 | Per-pin open-drain flag |
| pin_pu | output | 16 | Per-pin pull-up request |
| pin_pd | output | 16 | Per-pin pull-down request |
| pin_af | output | 64 | Per-pin alternate-function index, 4 bits per pin |

## Verification
Every register write, set/clear operation and lock step is due one cycle after it is issued. Its result is visible on bus_rdata and on the pin outputs right after the write edge. The bench therefore samples outputs half a cycle after each write edge. The input path is due two edges after a pad change. The bench drives pad_in on a falling edge and reads once after the first rising edge, where the old value must remain, and once after the second, where the new value must appear. The lock checks read address 7 after the third write, and then check each locked register with one write that covers locked and unlocked pins together.

// File: rtl/gpio_lock_port.sv
module gpio_lock_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] pad_in,
  input  logic [15:0] alt_dout,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe,
  output logic [15:0] pin_od,
  output logic [15:0] pin_pu,
  output logic [15:0] pin_pd,
  output logic [63:0] pin_af
);
  localparam int NPIN = 16;
  localparam logic [3:0] A_MODE = 4'd0, A_OTYPE = 4'd1, A_SPEED = 4'd2, A_PULL = 4'd3,
                         A_IN = 4'd4, A_OUT = 4'd5, A_SETCLR = 4'd6, A_LOCK = 4'd7,
                         A_AFLO = 4'd8, A_AFHI = 4'd9;
  localparam int KEYBIT = NPIN;

  logic [2*NPIN-1:0] mode_q, speed_q, pull_q, keep2;
  logic [NPIN-1:0]   otype_q, odr_q, sync_q, idr_q, lock_q, seq_mask_q;
  logic [31:0]       af_lo_q, af_hi_q, keep_lo, keep_hi;
  logic              key_q;
  logic [1:0]        seq_q;

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_pin
      assign keep2[2*g +: 2] = {2{lock_q[g]}};
      assign pin_oe[g] = (mode_q[2*g +: 2] == 2'b01) || (mode_q[2*g +: 2] == 2'b10);
      assign pin_out[g] = (mode_q[2*g +: 2] == 2'b10) ? alt_dout[g] : odr_q[g];
      assign pin_pu[g] = pull_q[2*g +: 2] == 2'b01;
      assign pin_pd[g] = pull_q[2*g +: 2] == 2'b10;
    end
    for (g = 0; g < NPIN/2; g++) begin : g_af
      assign keep_lo[4*g +: 4] = {4{lock_q[g]}};
      assign keep_hi[4*g +: 4] = {4{lock_q[g+NPIN/2]}};
    end
  endgenerate

  assign pin_od = otype_q & pin_oe;
  assign pin_af = {af_hi_q, af_lo_q};

  wire wr_lock  = bus_we && bus_addr == A_LOCK;
  wire key_in   = bus_wdata[KEYBIT];
  wire same_msk = bus_wdata[NPIN-1:0] == seq_mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; otype_q <= '0; speed_q <= '0; pull_q <= '0;
      af_lo_q <= '0; af_hi_q <= '0; odr_q <= '0;
      sync_q <= '0; idr_q <= '0;
      lock_q <= '0; key_q <= 1'b0; seq_q <= 2'd0; seq_mask_q <= '0;
    end else begin
      sync_q <= pad_in;
      idr_q  <= sync_q;
      if (bus_we) begin
        case (bus_addr)
          A_MODE:   mode_q  <= (bus_wdata & ~keep2) | (mode_q & keep2);
          A_OTYPE:  otype_q <= (bus_wdata[NPIN-1:0] & ~lock_q) | (otype_q & lock_q);
          A_SPEED:  speed_q <= (bus_wdata & ~keep2) | (speed_q & keep2);
          A_PULL:   pull_q  <= (bus_wdata & ~keep2) | (pull_q & keep2);
          A_AFLO:   af_lo_q <= (bus_wdata & ~keep_lo) | (af_lo_q & keep_lo);
          A_AFHI:   af_hi_q <= (bus_wdata & ~keep_hi) | (af_hi_q & keep_hi);
          A_OUT:    odr_q   <= bus_wdata[NPIN-1:0];
          A_SETCLR: odr_q   <= (odr_q & ~bus_wdata[31:16]) | bus_wdata[NPIN-1:0];
          default: ;
        endcase
      end
      if (wr_lock && !key_q) begin
        case (seq_q)
          2'd0: if (key_in) begin
                  seq_q <= 2'd1;
                  seq_mask_q <= bus_wdata[NPIN-1:0];
                end
          2'd1: seq_q <= (!key_in && same_msk) ? 2'd2 : 2'd0;
          default: begin
            seq_q <= 2'd0;
            if (key_in && same_msk) begin
              lock_q <= seq_mask_q;
              key_q  <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_OTYPE: bus_rdata = {16'h0, otype_q};
      A_SPEED: bus_rdata = speed_q;
      A_PULL:  bus_rdata = pull_q;
      A_IN:    bus_rdata = {16'h0, idr_q};
      A_OUT:   bus_rdata = {16'h0, odr_q};
      A_LOCK:  bus_rdata = {15'h0, key_q, lock_q};
      A_AFLO:  bus_rdata = af_lo_q;
      A_AFHI:  bus_rdata = af_hi_q;
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

module gpio_lock_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [15:0] pin_oe,
  input logic [15:0] pin_od,
  input logic [15:0] odr_q,
  input logic [31:0] mode_q,
  input logic [15:0] lock_q,
  input logic        key_q
);
  logic [31:0] lk2;
  always_comb
    for (int i = 0; i < 16; i++) lk2[2*i +: 2] = {2{lock_q[i]}};

  wire setclr_wr = bus_we && bus_addr == 4'd6;

  a_r5_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
    setclr_wr |=> (odr_q & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0]));
  a_r5_clear_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
    setclr_wr |=> (odr_q & $past(bus_wdata[31:16] & ~bus_wdata[15:0])) == 16'h0);
  a_r6_key_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    key_q |=> key_q && $stable(lock_q));
  a_r6_no_lock_without_key: assert property (@(posedge clk) disable iff (!rst_n)
    !key_q |-> lock_q == 16'h0);
  a_r7_locked_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    key_q |=> ((mode_q ^ $past(mode_q)) & $past(lk2)) == 32'h0);
  a_r3_od_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_od & ~pin_oe) == 16'h0);
endmodule

bind gpio_lock_port gpio_lock_port_chk u_chk (.*);

// File: tb/test_gpio_lock_port.sv
module test_gpio_lock_port;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] pad_in = 0, alt_dout = 0;
  logic [15:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd;
  logic [63:0] pin_af;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  gpio_lock_port i_gpio_lock_port (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d); check("R1 reg", {32'h0, d}, 64'h0);
    end
    check("R1 oe", {48'h0, pin_oe}, 0);
    check("R1 od", {48'h0, pin_od}, 0);
    check("R1 pull", {32'h0, pin_pu, pin_pd}, 0);
    check("R1 af", pin_af, 0);
  endtask

  task automatic t_mode;
    logic [31:0] d;
    wr(0, 32'h0000_0039);
    wr(5, 32'h0000_0001);
    alt_dout = 16'h0002; #1;
    rd(0, d); check("R2 readback", {32'h0, d}, 64'h39);
    check("R2 oe", {48'h0, pin_oe}, 64'h0003);
    check("R2 out", {48'h0, pin_out & 16'h000F}, 64'h0003);
    alt_dout = 16'h0000; #1;
    check("R2 alt follows", {48'h0, pin_out & 16'h000F}, 64'h0001);
  endtask

  task automatic t_type_pull;
    logic [31:0] d;
    wr(1, 32'h0000_0007);
    check("R3 od", {48'h0, pin_od}, 64'h0003);
    wr(3, 32'h0000_0039);
    check("R3 pu", {48'h0, pin_pu}, 64'h0001);
    check("R3 pd", {48'h0, pin_pd}, 64'h0002);
    wr(2, 32'hAAAA_5555);
    rd(2, d); check("R3 speed", {32'h0, d}, 64'hAAAA_5555);
  endtask

  task automatic t_af;
    wr(8, 32'h7654_3210);
    wr(9, 32'hFEDC_BA98);
    check("R4 af", pin_af, 64'hFEDCBA98_76543210);
    check("R4 pin9", {60'h0, pin_af[36 +: 4]}, 64'h9);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(5, 32'h0000_00F0);
    wr(6, 32'h0031_0101);
    rd(5, d); check("R5 set/clear, set wins", {32'h0, d}, 64'h01C1);
    rd(6, d); check("R5 reads zero", {32'h0, d}, 64'h0);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    wr(7, 32'h0001_000F); wr(7, 32'h0000_00FF);
    wr(7, 32'h0000_000F);
    wr(7, 32'h0001_000F); wr(7, 32'h0001_000F);
    rd(7, d); check("R8 abort nothing locked", {32'h0, d}, 64'h0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R8 mode writable", {32'h0, d}, 64'hFFFF_FFFF);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr(7, 32'h0001_00F0); wr(7, 32'h0000_00F0); wr(7, 32'h0001_00F0);
    rd(7, d); check("R6 key and mask", {32'h0, d}, 64'h0001_00F0);
    wr(7, 32'h0001_0F00); wr(7, 32'h0000_0F00); wr(7, 32'h0001_0F00);
    rd(7, d); check("R6 relock ignored", {32'h0, d}, 64'h0001_00F0);
  endtask

  task automatic t_locked;
    logic [31:0] d;
    wr(0, 32'h0); rd(0, d); check("R7 mode", {32'h0, d}, 64'h0000_FF00);
    wr(1, 32'hFFFF); rd(1, d); check("R7 otype", {32'h0, d}, 64'hFF0F);
    wr(2, 32'h0); rd(2, d); check("R7 speed", {32'h0, d}, 64'h0000_5500);
    wr(3, 32'hFFFF_FFFF); rd(3, d); check("R7 pull", {32'h0, d}, 64'hFFFF_00FF);
    wr(8, 32'h0); rd(8, d); check("R7 af low", {32'h0, d}, 64'h7654_0000);
    wr(9, 32'h1111_1111); rd(9, d); check("R7 af high unlocked", {32'h0, d}, 64'h1111_1111);
  endtask

  task automatic t_odr_locked;
    logic [31:0] d;
    wr(5, 32'h0000_00F0); rd(5, d); check("R9 odr write", {32'h0, d}, 64'h00F0);
    wr(6, 32'h0010_0100); rd(5, d); check("R9 set/clear", {32'h0, d}, 64'h01E0);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk); pad_in = 16'hA5C3;
    @(posedge clk); #1; rd(4, d); check("R10 one edge old", {32'h0, d}, 64'h0);
    @(posedge clk); #1; rd(4, d); check("R10 two edges new", {32'h0, d}, 64'hA5C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_mode; t_type_pull; t_af; t_setclr;
    t_abort; t_lock; t_locked; t_odr_locked; t_input;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule